// File: doc/BRIEF.md
# Triggered Block Capture Recorder

The recorder captures a fixed-length burst of converter samples into on-chip memory and keeps them there until a host drains them. The host sends a single one-cycle trigger. After that the block runs unattended. A rate timer, divided down from the system clock, marks each sample period. At the start of every period the block sends a one-cycle convert request to an external converter interface. It then waits for that interface's data-valid strobe. Each returned sample is written at the next memory address, starting from zero.

When the last sample of the record has been written, the block stops requesting conversions and raises a done flag. The host then reads the record in address order through a read-strobe port, at whatever pace suits it. Two sticky error bits cover the unusual cases. One reports a converter that missed a sample period. The other reports a host that read beyond the end of the record.

With the default divider of 10,000 and a 100 MHz clock, the block takes 10,000 samples per second. A full ten-second record needs the record-length parameter raised to 100,000. The default is kept at 2,048 words so the memory stays small.

Top module: `block_capture_recorder`

## Requirements
- R1: Out of reset, the done, overrun and underrun flags are low, and no convert request is issued until a trigger arrives.
- R2: A trigger while the block is idle or done starts a capture. It clears the done, overrun and underrun flags, rewinds the read pointer to address 0, and raises the first convert request in the cycle after the trigger.
- R3: While capturing, the convert request is one cycle wide and repeats every CLK_DIV cycles.
- R4: A data-valid strobe that answers an outstanding request stores its sample at the next consecutive address, starting at 0. A data-valid strobe with no request outstanding stores nothing.
- R5: Once the RECORD_LEN-th sample is stored, the done flag rises in the next cycle and stays high, and no further convert request is issued.
- R6: A trigger that arrives during a capture is ignored. The capture continues with its period, addresses and length unchanged.
- R7: The read data output shows the word at the read pointer. A read strobe while done advances the pointer by one. A read strobe before done has no effect on the pointer.
- R8: When the read pointer sits one past the last sample, the read data is zero. A read strobe there sets a sticky underrun flag and leaves the pointer in place.
- R9: If a sample period ends while a request is still outstanding and no data-valid strobe arrives in that cycle, the sticky overrun flag is set and that sample is never stored. A data-valid strobe in the boundary cycle itself is still stored.
- R10: Sample width (default 10 bits), record length and clock divider are parameters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| trigIn | input | 1 | One-cycle capture trigger from the host |
| convPulse | output | 1 | One-cycle convert request to the converter |
| sampleValid | input | 1 | Converter data-valid strobe |
| sampleData | input | SAMPLE_W | Converter sample word |
| doneFlag | output | 1 | Record complete and readable |
| overrunFlag | output | 1 | Sticky: a sample period was missed |
| rdStrobe | input | 1 | Host read strobe, advances the read pointer |
| rdData | output | SAMPLE_W | Word at the read pointer, zero past the end |
| underrunFlag | output | 1 | Sticky: a read past the end of the record |

## Verification
The bench builds the block with RECORD_LEN = 16 and CLK_DIV = 8. A whole record therefore takes about 130 cycles, and every stored word can be read back and compared with an arithmetic prediction. At this size the bench can measure every convert period exactly. It can place the converter's reply at zero delay, at mid-period and on the period boundary itself, and can delay one reply past the boundary to force an overrun at a chosen index. A stray data-valid strobe, a mid-capture trigger and reads before done and past the end are also applied, each with a checkable trace in the record.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } capState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic restart;  // rewind write address, read pointer, underrun
    logic wrEn;     // store sampleData at write address
    logic rdAdv;    // host read strobe accepted
  } capStrobe_t;
endpackage

// File: rtl/cap_ctrl.sv
module cap_ctrl
  import cap_pkg::*;
#(
  parameter int CLK_DIV = 10000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       trigIn,
  input  logic       sampleValid,
  input  logic       rdStrobe,
  input  logic       lastWrite,
  output logic       convPulse,
  output logic       doneFlag,
  output logic       overrunFlag,
  output capStrobe_t strobes
);
  localparam int TICK_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(CLK_DIV - 1);

  capState_t state;
  logic [TICK_W-1:0] tick;
  logic waiting;
  logic overrun;
  logic start;
  logic accept;

  assign start  = trigIn && (state != ST_RUN);
  assign accept = (state == ST_RUN) && waiting && sampleValid;

  assign convPulse   = (state == ST_RUN) && (tick == '0);
  assign doneFlag    = (state == ST_DONE);
  assign overrunFlag = overrun;

  assign strobes.restart = start;
  assign strobes.wrEn    = accept;
  assign strobes.rdAdv   = (state == ST_DONE) && rdStrobe && !trigIn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tick    <= '0;
      waiting <= 1'b0;
      overrun <= 1'b0;
    end else if (start) begin
      state   <= ST_RUN;
      tick    <= '0;
      waiting <= 1'b0;
      overrun <= 1'b0;
    end else if (state == ST_RUN) begin
      tick <= (tick == TICK_LAST) ? '0 : tick + 1'b1;
      if (convPulse) waiting <= 1'b1;
      else if (accept) waiting <= 1'b0;
      if (convPulse && waiting && !sampleValid) overrun <= 1'b1;
      if (accept && lastWrite) state <= ST_DONE;
    end
  end

  // R3
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    (CLK_DIV > 1) && convPulse |=> !convPulse);
  // R5
  done_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneFlag && !trigIn |=> doneFlag && !convPulse);
  // R9
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    overrunFlag && !trigIn |=> overrunFlag);
  // R6
  trig_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN) && trigIn && !(accept && lastWrite) |=> (state == ST_RUN));
endmodule

// File: rtl/cap_datapath.sv
module cap_datapath
  import cap_pkg::*;
#(
  parameter int SAMPLE_W   = 10,
  parameter int RECORD_LEN = 2048
) (
  input  logic                clk,
  input  logic                rstN,
  input  capStrobe_t          strobes,
  input  logic [SAMPLE_W-1:0] sampleData,
  output logic                lastWrite,
  output logic [SAMPLE_W-1:0] rdData,
  output logic                underrunFlag
);
  localparam int ADDR_W = $clog2(RECORD_LEN + 1);
  localparam int IDX_W  = (RECORD_LEN > 1) ? $clog2(RECORD_LEN) : 1;
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(RECORD_LEN - 1);
  localparam logic [ADDR_W-1:0] END_ADDR  = ADDR_W'(RECORD_LEN);

  logic [SAMPLE_W-1:0] mem [RECORD_LEN];
  logic [ADDR_W-1:0] wrAddr;
  logic [ADDR_W-1:0] rdPtr;
  logic underrun;

  assign lastWrite    = (wrAddr == LAST_ADDR);
  assign underrunFlag = underrun;
  assign rdData       = (rdPtr == END_ADDR) ? '0 : mem[rdPtr[IDX_W-1:0]];

  always_ff @(posedge clk) begin
    if (strobes.wrEn && (wrAddr != END_ADDR)) mem[wrAddr[IDX_W-1:0]] <= sampleData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrAddr   <= '0;
      rdPtr    <= '0;
      underrun <= 1'b0;
    end else if (strobes.restart) begin
      wrAddr   <= '0;
      rdPtr    <= '0;
      underrun <= 1'b0;
    end else begin
      if (strobes.wrEn && (wrAddr != END_ADDR)) wrAddr <= wrAddr + 1'b1;
      if (strobes.rdAdv) begin
        if (rdPtr == END_ADDR) underrun <= 1'b1;
        else rdPtr <= rdPtr + 1'b1;
      end
    end
  end

  // R7
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.rdAdv && !strobes.restart |=> $stable(rdPtr));
  // R8
  underrun_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    underrunFlag && !strobes.restart |=> underrunFlag && (rdData == '0));
  // R4
  wr_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrAddr <= END_ADDR);
endmodule

// File: rtl/block_capture_recorder.sv
module block_capture_recorder
  import cap_pkg::*;
#(
  parameter int SAMPLE_W   = 10,
  parameter int RECORD_LEN = 2048,
  parameter int CLK_DIV    = 10000
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                trigIn,
  output logic                convPulse,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sampleData,
  output logic                doneFlag,
  output logic                overrunFlag,
  input  logic                rdStrobe,
  output logic [SAMPLE_W-1:0] rdData,
  output logic                underrunFlag
);
  capStrobe_t strobes;
  logic lastWrite;

  cap_ctrl #(.CLK_DIV(CLK_DIV)) uCtrl (
    .clk(clk), .rstN(rstN), .trigIn(trigIn), .sampleValid(sampleValid),
    .rdStrobe(rdStrobe), .lastWrite(lastWrite), .convPulse(convPulse),
    .doneFlag(doneFlag), .overrunFlag(overrunFlag), .strobes(strobes)
  );

  cap_datapath #(.SAMPLE_W(SAMPLE_W), .RECORD_LEN(RECORD_LEN)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .sampleData(sampleData),
    .lastWrite(lastWrite), .rdData(rdData), .underrunFlag(underrunFlag)
  );
endmodule

// File: tb/sim_block_capture_recorder.sv
module sim_block_capture_recorder;
  localparam int W = 10;
  localparam int LEN = 16;
  localparam int DIV = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic trigIn = 1'b0;
  logic convPulse;
  logic sampleValid = 1'b0;
  logic [W-1:0] sampleData = '0;
  logic doneFlag, overrunFlag, underrunFlag;
  logic rdStrobe = 1'b0;
  logic [W-1:0] rdData;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  // converter model state
  int reqIdx = 0;
  int runId = 0;
  int lat = 0;
  int skipIdx = -1;
  bit strayOn = 0;
  bit pend = 0;
  int cnt = 0;
  int pendIdx = 0;
  bit gave = 0;
  bit havePrev = 0;
  int lastPulse = 0;

  always #5 clk = ~clk;

  block_capture_recorder #(.SAMPLE_W(W), .RECORD_LEN(LEN), .CLK_DIV(DIV)) u0 (
    .clk(clk), .rstN(rstN), .trigIn(trigIn), .convPulse(convPulse),
    .sampleValid(sampleValid), .sampleData(sampleData), .doneFlag(doneFlag),
    .overrunFlag(overrunFlag), .rdStrobe(rdStrobe), .rdData(rdData),
    .underrunFlag(underrunFlag)
  );

  function automatic logic [W-1:0] mk(int r, int i);
    logic [1:0] rb = r[1:0];
    logic [7:0] ib = i[7:0];
    return {rb, ib};
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finishUp();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // converter model, acts on falling edges only
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      sampleValid = 1'b0;
      if (pend) begin
        if (cnt == 0) begin
          sampleValid = 1'b1;
          sampleData = mk(runId, pendIdx);
          pend = 0;
          gave = 1;
        end else cnt--;
      end else if (gave && strayOn) begin
        sampleValid = 1'b1;  // R4: stray strobe with nothing outstanding
        sampleData = 10'h3FF;
        gave = 0;
      end else gave = 0;
      if (convPulse) begin
        // R3: period and width
        if (havePrev) chk(cyc - lastPulse == DIV, "R3 period", cyc - lastPulse, DIV);
        havePrev = 1;
        lastPulse = cyc;
        pend = 1;
        pendIdx = reqIdx;
        cnt = (reqIdx == skipIdx) ? 3 * DIV : lat;
        reqIdx++;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    finishUp();
  end

  task automatic trigger(bit fresh);
    @(negedge clk);
    #1;
    trigIn = 1'b1;
    if (fresh) begin
      reqIdx = 0;
      havePrev = 0;
      pend = 0;
      gave = 0;
    end
    @(negedge clk);
    if (fresh) chk(convPulse == 1'b1, "R2 first convert", int'(convPulse), 1);
    #1;
    trigIn = 1'b0;
  endtask

  task automatic waitDone();
    int n = 0;
    while (!doneFlag && n < LEN * DIV * 6) begin
      @(negedge clk);
      n++;
    end
    chk(doneFlag == 1'b1, "R5 done", int'(doneFlag), 1);
    repeat (2 * DIV) @(negedge clk);
    chk(doneFlag == 1'b1, "R5 done held", int'(doneFlag), 1);
  endtask

  task automatic readOne(int exp, string tag);
    chk(rdData == W'(exp), tag, int'(rdData), exp);
    rdStrobe = 1'b1;
    @(negedge clk);
    rdStrobe = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(doneFlag == 0, "R1 done", int'(doneFlag), 0);
    chk(overrunFlag == 0, "R1 overrun", int'(overrunFlag), 0);
    chk(underrunFlag == 0, "R1 underrun", int'(underrunFlag), 0);
    chk(convPulse == 0, "R1 convert", int'(convPulse), 0);
    rstN = 1'b1;
    repeat (DIV * 2) begin
      @(negedge clk);
      chk(convPulse == 0, "R1 no convert before trigger", int'(convPulse), 0);
    end
    // R7: strobe before any capture does nothing
    rdStrobe = 1'b1;
    @(negedge clk);
    rdStrobe = 1'b0;
    chk(underrunFlag == 0, "R7 strobe ignored idle", int'(underrunFlag), 0);

    // Run A: immediate replies
    runId = 1; lat = 0; skipIdx = -1; strayOn = 0;
    trigger(1);
    waitDone();
    chk(overrunFlag == 0, "R9 no overrun", int'(overrunFlag), 0);
    for (int i = 0; i < LEN; i++) readOne(int'(mk(1, i)), "R4 run A word");
    chk(rdData == '0, "R8 zero past end", int'(rdData), 0);
    rdStrobe = 1'b1;
    @(negedge clk);
    rdStrobe = 1'b0;
    chk(underrunFlag == 1, "R8 underrun set", int'(underrunFlag), 1);
    readOne(0, "R8 zero after underrun");
    chk(underrunFlag == 1, "R8 underrun sticky", int'(underrunFlag), 1);

    // Run B: mid-period replies, stray strobe, mid-capture trigger, early read
    runId = 2; lat = 3; strayOn = 1;
    trigger(1);
    chk(doneFlag == 0, "R2 done cleared", int'(doneFlag), 0);
    chk(underrunFlag == 0, "R2 underrun cleared", int'(underrunFlag), 0);
    repeat (5 * DIV) @(negedge clk);
    trigger(0);  // R6
    rdStrobe = 1'b1;  // R7: read before done
    @(negedge clk);
    rdStrobe = 1'b0;
    waitDone();
    chk(reqIdx == LEN, "R6 conversions per capture", reqIdx, LEN);
    for (int i = 0; i < LEN; i++) readOne(int'(mk(2, i)), "R6 R7 run B word");
    chk(underrunFlag == 0, "R7 no underrun at end", int'(underrunFlag), 0);

    // Run C: replies on the boundary cycle, one reply late
    runId = 3; lat = DIV - 1; strayOn = 0; skipIdx = 5;
    trigger(1);
    waitDone();
    chk(overrunFlag == 1, "R9 overrun set", int'(overrunFlag), 1);
    for (int i = 0; i < LEN; i++)
      readOne(int'(mk(3, (i < 5) ? i : i + 1)), "R9 run C word");

    // Run D: restart clears overrun
    runId = 0; lat = 1; skipIdx = -1;
    trigger(1);
    chk(overrunFlag == 0, "R2 overrun cleared", int'(overrunFlag), 0);
    waitDone();
    for (int i = 0; i < LEN; i++) readOne(int'(mk(0, i)), "R10 run D word");
    finishUp();
  end
endmodule